// File: doc/BRIEF.md
# Fractional Prescaler to Centisecond Tick

This block turns a crystal-rate clock into the timing enables that a real-time clock's counters need. The crystal runs at one of four power-of-two rates, and a 2-bit select field chosen by software says which one. No integer ratio turns such a rate into 4000 Hz. The block therefore uses a phase accumulator: it adds the target tick rate once per crystal cycle, modulo the crystal frequency, and emits a base strobe on each wrap. Each crystal second holds exactly the target number of base strobes. The spacing between them varies by at most one crystal cycle.

A decade chain follows the accumulator. It divides the base strobes by the prescale ratio to make a 100 Hz enable, then by ten for 10 Hz, then by ten again for 1 Hz. Every strobe lasts one clock cycle. Where strobes coincide, they rise in the same cycle. The 100 Hz and 10 Hz strobes inherit the jitter of the fractional step. The error adds up to zero over every second, so the 1 Hz strobe is exact. A change of the select field restarts the accumulator and the chain, and the next second begins from a clean phase.

Top module: `centi_tick_prescaler`

## Requirements
- R1: While `rst_n` is low at a rising edge, all four strobes are low in the following cycle, and the accumulator and decade counters start again from zero.
- R2: Select code s gives a crystal of 2^n cycles per second, with n = `LOG2_SEL0`..`LOG2_SEL3` for s = 0..3 (15, 20, 21, 22 by default). Counting k rising edges since the last restart, `strobe_base` is high after edge k exactly when floor(k·TICK_HZ/2^n) > floor((k-1)·TICK_HZ/2^n).
- R3: Any 2^n consecutive cycles that start at a restart contain exactly `TICK_HZ` base strobes.
- R4: `strobe_centi` is high in the same cycle as every (TICK_HZ/100)-th base strobe counted from restart, and at no other time. There are 100 of them per second.
- R5: `strobe_deci` is high in the same cycle as every tenth centi strobe, and at no other time.
- R6: `strobe_sec` is high in the same cycle as every tenth deci strobe. It first rises 2^n cycles after a restart and then repeats every 2^n cycles exactly.
- R7: When `freq_sel` differs at a rising edge from its value at the previous edge, that edge acts as a restart. No strobe is high in the following cycle, and the counting of R2 starts from k = 0 with the new rate.
- R8: Every strobe is high for a single cycle. The base strobe is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_sel | input | 2 | Crystal rate select code (see R2) |
| strobe_base | output | 1 | Fractional base-rate strobe (TICK_HZ per second) |
| strobe_centi | output | 1 | 100 Hz strobe |
| strobe_deci | output | 1 | 10 Hz strobe |
| strobe_sec | output | 1 | 1 Hz strobe, exact period |

## Verification
The testbench drives all four select codes for two full seconds each. This separates a wrong code-to-rate mapping from a wrong wrap point, because each code has its own expected second length and its own base-strobe spacing. A select change in the middle of a second shows whether the restart clears the accumulator's phase and the partial decade counts. A reset in the middle of a run does the same for the reset path. The bench predicts every strobe cycle by cycle from the floor formula of R2 and the decade divisions. It also totals the strobes per second, so a one-cycle drift in the phase step shows up both as a wrong strobe position and as a wrong count.

// File: rtl/prescale_pkg.sv
// Package: shared types and helpers for the centisecond prescaler.
// Assumes the decade chain always has three stages: prescale, /10, /10.
package prescale_pkg;

    localparam int DECADE      = 10;
    localparam int CHAIN_DEPTH = 3;

    typedef logic [1:0] rate_sel_t;

    // Divide ratio of decade stage idx; stage 0 takes the prescale ratio.
    function automatic int stage_div(input int idx, input int pre_div);
        return (idx == 0) ? pre_div : DECADE;
    endfunction

    // Largest of the four crystal exponents, used to size the accumulator.
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sel_tracker.sv
// Module: sel_tracker
// Registers the rate select code and flags any edge at which it differs from
// the value held at the previous edge. That flag restarts the phase
// accumulator and the decade chain.
// Assumes freq_sel is already synchronous to clk.
module sel_tracker
    import prescale_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  rate_sel_t sel_i,
    output rate_sel_t sel_q_o,
    output logic      restart_o
);

    rate_sel_t sel_q;

    // Hold the select value seen at the last edge.
    always_ff @(posedge clk) begin
        sel_q <= sel_i;
    end

    // Restart when the select changes; held low in reset (reset clears anyway).
    always_comb begin
        restart_o = rst_n && (sel_i != sel_q);
    end

    assign sel_q_o = sel_q;

endmodule

// File: rtl/frac_accum.sv
// Module: frac_accum
// Phase accumulator. Each cycle it adds INC modulo 2^n, where n is the crystal
// exponent picked by the select code, and it registers the carry out of bit n
// as a one-cycle strobe. Over 2^n cycles from a zero phase it gives exactly
// INC strobes.
// Assumes INC < 2^(n-1) for every code, so strobes never touch.
module frac_accum
    import prescale_pkg::*;
#(
    parameter int ACC_W = 22,
    parameter int INC   = 4000,
    parameter int L0    = 15,
    parameter int L1    = 20,
    parameter int L2    = 21,
    parameter int L3    = 22
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart_i,
    input  rate_sel_t sel_i,
    output logic      strobe_o
);

    localparam int LG_W = $clog2(ACC_W + 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W:0]   sum;
    logic [ACC_W:0]   lim_mask;
    logic [LG_W-1:0]  lg;
    logic             wrap;
    logic             strobe_q;

    // Map the select code to the crystal exponent.
    always_comb begin
        case (sel_i)
            2'd0:    lg = LG_W'(L0);
            2'd1:    lg = LG_W'(L1);
            2'd2:    lg = LG_W'(L2);
            default: lg = LG_W'(L3);
        endcase
    end

    // Add the phase step and fold the sum back into [0, 2^n).
    always_comb begin
        sum      = {1'b0, acc_q} + (ACC_W + 1)'(INC);
        lim_mask = ((ACC_W + 1)'(1) << lg) - (ACC_W + 1)'(1);
        wrap     = sum[lg];
        acc_d    = sum[ACC_W-1:0] & lim_mask[ACC_W-1:0];
    end

    // Advance the phase and register the wrap strobe; clear on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            acc_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            acc_q    <= acc_d;
            strobe_q <= wrap;
        end
    end

    assign strobe_o = strobe_q;

endmodule

// File: rtl/decade_stage.sv
// Module: decade_stage
// Divide-by-N enable counter. The carry is combinational: it is high in the
// same cycle as the N-th enable, so stages chained in series stay aligned.
// Assumes N >= 2 and enables that last a single cycle.
module decade_stage #(
    parameter int N = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic en_i,
    output logic carry_o
);

    localparam int CW = (N > 2) ? $clog2(N) : 1;

    logic [CW-1:0] cnt_q;
    logic          at_top;

    // Last count of the cycle marks the carry.
    always_comb begin
        at_top  = (cnt_q == CW'(N - 1));
        carry_o = en_i && at_top;
    end

    // Count enables modulo N; clear on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= at_top ? '0 : cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/centi_tick_prescaler.sv
// Module: centi_tick_prescaler (top)
// Fractional prescaler. A phase accumulator derives TICK_HZ strobes per crystal
// second, and a decade chain turns them into 100 Hz, 10 Hz and 1 Hz strobes
// that share an edge. A change of select restarts everything.
// Assumes TICK_HZ is a multiple of 100 and below 2^(n-1) for every code.
module centi_tick_prescaler
    import prescale_pkg::*;
#(
    parameter int TICK_HZ   = 4000,
    parameter int LOG2_SEL0 = 15,
    parameter int LOG2_SEL1 = 20,
    parameter int LOG2_SEL2 = 21,
    parameter int LOG2_SEL3 = 22
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] freq_sel,
    output logic       strobe_base,
    output logic       strobe_centi,
    output logic       strobe_deci,
    output logic       strobe_sec
);

    localparam int ACC_W   = max4(LOG2_SEL0, LOG2_SEL1, LOG2_SEL2, LOG2_SEL3);
    localparam int PRE_DIV = TICK_HZ / 100;

    rate_sel_t              sel_q;
    logic                   restart;
    logic [CHAIN_DEPTH:0]   chain;

    sel_tracker u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (freq_sel),
        .sel_q_o   (sel_q),
        .restart_o (restart)
    );

    frac_accum #(
        .ACC_W (ACC_W),
        .INC   (TICK_HZ),
        .L0    (LOG2_SEL0),
        .L1    (LOG2_SEL1),
        .L2    (LOG2_SEL2),
        .L3    (LOG2_SEL3)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .sel_i     (sel_q),
        .strobe_o  (chain[0])
    );

    // Chain the decade stages; each carry enables the next.
    for (genvar gi = 0; gi < CHAIN_DEPTH; gi++) begin : g_stage
        decade_stage #(
            .N (stage_div(gi, PRE_DIV))
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (restart),
            .en_i    (chain[gi]),
            .carry_o (chain[gi+1])
        );
    end

    assign strobe_base  = chain[0];
    assign strobe_centi = chain[1];
    assign strobe_deci  = chain[2];
    assign strobe_sec   = chain[3];

endmodule

// File: rtl/centi_tick_prescaler_chk.sv
// Checker for centi_tick_prescaler. It keeps its own record of the select
// code and its own count of cycles since the last restart or second strobe.
module centi_tick_prescaler_chk #(
    parameter int LOG2_SEL0 = 15,
    parameter int LOG2_SEL1 = 20,
    parameter int LOG2_SEL2 = 21,
    parameter int LOG2_SEL3 = 22
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] freq_sel,
    input logic       strobe_base,
    input logic       strobe_centi,
    input logic       strobe_deci,
    input logic       strobe_sec
);

    logic [1:0] sel_seen;
    int         since;
    int         period;

    // Length of one second for the code now in force.
    always_comb begin
        case (sel_seen)
            2'd0:    period = 1 << LOG2_SEL0;
            2'd1:    period = 1 << LOG2_SEL1;
            2'd2:    period = 1 << LOG2_SEL2;
            default: period = 1 << LOG2_SEL3;
        endcase
    end

    // Count cycles since restart, or since the last second strobe.
    always_ff @(posedge clk) begin
        sel_seen <= freq_sel;
        if (!rst_n || freq_sel != sel_seen) since <= 0;
        else if (strobe_sec)                since <= 1;
        else                                since <= since + 1;
    end

    a_r8_base_single: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_base |=> !strobe_base);

    a_r4_centi_on_base: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_centi |-> strobe_base);

    a_r5_deci_on_centi: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_deci |-> strobe_centi);

    a_r6_sec_on_deci: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_sec |-> strobe_deci);

    a_r6_sec_period: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_sec |-> (since == period));

    a_r6_sec_due: assert property (@(posedge clk) disable iff (!rst_n)
        (since == period) |-> strobe_sec);

    a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_sel != $past(freq_sel)) |=> !strobe_base);

endmodule

bind centi_tick_prescaler centi_tick_prescaler_chk #(
    .LOG2_SEL0 (LOG2_SEL0),
    .LOG2_SEL1 (LOG2_SEL1),
    .LOG2_SEL2 (LOG2_SEL2),
    .LOG2_SEL3 (LOG2_SEL3)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .freq_sel     (freq_sel),
    .strobe_base  (strobe_base),
    .strobe_centi (strobe_centi),
    .strobe_deci  (strobe_deci),
    .strobe_sec   (strobe_sec)
);

// File: tb/sim_centi_tick_prescaler.sv
// Bench: sweeps every select code over two whole seconds at a reduced scale.
// It predicts every strobe from the floor formula and the decade ratios.
module sim_centi_tick_prescaler;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = CLK_PERIOD / 4;
    localparam int TICK       = 400;
    localparam int PRE        = TICK / 100;
    localparam int L0 = 10, L1 = 11, L2 = 12, L3 = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] freq_sel = 2'd0;
    logic       strobe_base, strobe_centi, strobe_deci, strobe_sec;

    int      checks = 0;
    int      fails  = 0;
    longint  k      = 0;
    int      cur_n  = L0;
    int      n_base, n_centi, n_deci, n_sec;

    always #(CLK_PERIOD/2) clk = ~clk;

    centi_tick_prescaler #(
        .TICK_HZ   (TICK),
        .LOG2_SEL0 (L0),
        .LOG2_SEL1 (L1),
        .LOG2_SEL2 (L2),
        .LOG2_SEL3 (L3)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .freq_sel     (freq_sel),
        .strobe_base  (strobe_base),
        .strobe_centi (strobe_centi),
        .strobe_deci  (strobe_deci),
        .strobe_sec   (strobe_sec)
    );

    function automatic int lg_of(input logic [1:0] s);
        case (s)
            2'd0:    return L0;
            2'd1:    return L1;
            2'd2:    return L2;
            default: return L3;
        endcase
    endfunction

    // Expected strobe after edge kk: a base wrap whose running total divides by m.
    function automatic logic exp_tick(input longint kk, input int n, input int m);
        longint t, tp;
        if (kk < 1) return 1'b0;
        t  = (kk * TICK) >> n;
        tp = ((kk - 1) * TICK) >> n;
        return (t != tp) && ((t % m) == 0);
    endfunction

    task automatic cmp(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at k=%0d n=%0d: actual %0d expected %0d",
                     req, what, k, cur_n, act, exp);
        end
    endtask

    task automatic check_zero(input string req);
        cmp(req, "base",  strobe_base,  0);
        cmp(req, "centi", strobe_centi, 0);
        cmp(req, "deci",  strobe_deci,  0);
        cmp(req, "sec",   strobe_sec,   0);
    endtask

    // One clock; compare all four strobes with the model (R2, R4, R5, R6).
    task automatic step();
        @(posedge clk);
        #Q;
        k++;
        cmp("R2", "base",  strobe_base,  exp_tick(k, cur_n, 1));
        cmp("R4", "centi", strobe_centi, exp_tick(k, cur_n, PRE));
        cmp("R5", "deci",  strobe_deci,  exp_tick(k, cur_n, PRE * 10));
        cmp("R6", "sec",   strobe_sec,   exp_tick(k, cur_n, PRE * 100));
        n_base  += int'(strobe_base);
        n_centi += int'(strobe_centi);
        n_deci  += int'(strobe_deci);
        n_sec   += int'(strobe_sec);
    endtask

    // Change the select; the next edge restarts with nothing pending (R7).
    task automatic switch_sel(input logic [1:0] s);
        freq_sel = s;
        @(posedge clk);
        #Q;
        k = 0;
        cur_n = lg_of(s);
        check_zero("R7");
    endtask

    // One full second from the current phase, then check the totals (R3, R4, R5, R6).
    task automatic one_second();
        n_base = 0; n_centi = 0; n_deci = 0; n_sec = 0;
        repeat (1 << cur_n) step();
        cmp("R3", "base count",  n_base,  TICK);
        cmp("R4", "centi count", n_centi, 100);
        cmp("R5", "deci count",  n_deci,  10);
        cmp("R6", "sec count",   n_sec,   1);
    endtask

    initial begin
        n_base = 0; n_centi = 0; n_deci = 0; n_sec = 0;
        // R1: reset state.
        repeat (3) @(posedge clk);
        #Q;
        check_zero("R1");
        rst_n = 1'b1;
        k = 0;
        cur_n = lg_of(2'd0);
        one_second();
        one_second();
        // Every other code, two seconds each (R2 code-to-rate mapping).
        for (int s = 1; s < 4; s++) begin
            switch_sel(2'(s));
            one_second();
            one_second();
        end
        // R7: switch in the middle of a second, then a clean second.
        switch_sel(2'd1);
        repeat (1500) step();
        switch_sel(2'd0);
        one_second();
        // R1: reset in the middle of a second restarts the phase.
        repeat (300) step();
        rst_n = 1'b0;
        @(posedge clk);
        #Q;
        check_zero("R1");
        rst_n = 1'b1;
        k = 0;
        one_second();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule